// File: doc/BRIEF.md
# CCD Clock Fragment Sequencer

This block plays back short clock-pattern fragments that drive the lines of a CCD readout chain: parallel and serial phases, the summing well, the output-node reset and the integrator controls. Each stored word pairs a 16-bit line pattern with a 12-bit hold count, so the data sets the parallel rate, the serial rate and the frame rate. No fixed logic sets them. A fragment is a run of consecutive words. Typical fragments are a parallel shift in either direction, a serial shift-and-read that sits between the two dual-slope integration windows, and a flush of one pixel.

Software fills the word memory and a fragment table through a simple write port. The table gives each of 16 fragment indices a start address and a word count. A request carries a fragment index and a repeat count. The block then steps through the fragment's words and holds each pattern for its programmed time. It loops over the whole fragment as many times as asked, for example to clock out a full line or to perform a frame transfer. When the last word's time has run out, it raises done for one cycle. The pattern output is registered and changes only at word boundaries.

Top module: `ccd_frag_seq`

## Requirements
- R1: While and after reset, `busy` and `done` are 0 and `line_pat` is all zeros.
- R2: A word whose hold count is N keeps its pattern on `line_pat` for exactly N+1 clock cycles. The first word of a run appears in the second cycle after the request is accepted.
- R3: A fragment's words are played in rising address order from its start address. The address wraps modulo the memory depth. The next word follows the previous one with no idle cycle between them.
- R4: The fragment is played back to back as many times as the repeat count says, with no gap between passes.
- R5: `done` is high for one cycle, in the cycle right after the last word's hold ends. `busy` falls in that same cycle.
- R6: A request made while `busy` is high is ignored. The current run carries on unchanged.
- R7: A request with a repeat count of zero, or one for a fragment of length zero, raises `done` in the next cycle. `busy` stays low and `line_pat` keeps its value.
- R8: Each fragment index picks its own start address and length from the table. These are as last written through the table write port.
- R9: After a run ends, `line_pat` keeps the last word's pattern until a new run loads a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wd_we | input | 1 | Write strobe for the word memory |
| wd_addr | input | 8 | Word memory write address |
| wd_pat | input | 16 | Line pattern to store |
| wd_hold | input | 12 | Hold count to store (pattern lasts count+1 cycles) |
| ft_we | input | 1 | Write strobe for the fragment table |
| ft_idx | input | 4 | Fragment index to write |
| ft_base | input | 8 | Start address of the fragment |
| ft_len | input | 9 | Number of words in the fragment (0 to 256) |
| req | input | 1 | Run request, accepted only while idle |
| req_frag | input | 4 | Fragment index of the request |
| req_reps | input | 16 | Number of passes over the fragment |
| line_pat | output | 16 | Registered CCD line pattern |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
A request is accepted at a clock edge, and `busy` rises after that same edge. The first pattern follows one edge later, and each word then holds for its count plus one edges. `done` and the fall of `busy` come one edge after the last word's hold ends. A request that does nothing gives `done` right after the accepting edge. The bench has a reference model that updates at each rising edge from the inputs seen there. It replays a queue of expected per-cycle patterns that it builds from its own copy of the memory and the table. All three outputs are compared with the model at every falling edge, so a result that comes one cycle early or late is caught where it occurs.

// File: rtl/ccd_frag_pkg.sv
package ccd_frag_pkg;
  typedef enum logic [0:0] {
    SQ_IDLE = 1'b0,
    SQ_RUN  = 1'b1
  } sq_state_e;
endpackage

// File: rtl/frag_word_ram.sv
module frag_word_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 28
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/frag_table.sv
module frag_table #(
  parameter int IDX_W  = 4,
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [ADDR_W-1:0] wbase,
  input  logic [LEN_W-1:0]  wlen,
  input  logic [IDX_W-1:0]  ridx,
  output logic [ADDR_W-1:0] rbase,
  output logic [LEN_W-1:0]  rlen
);
  localparam int NFRAG = 1 << IDX_W;

  logic [ADDR_W-1:0] base_q [NFRAG];
  logic [LEN_W-1:0]  len_q  [NFRAG];

  generate
    for (genvar g = 0; g < NFRAG; g++) begin : g_ent
      always_ff @(posedge clk) begin
        if (rst) begin
          base_q[g] <= '0;
          len_q[g]  <= '0;
        end else if (we && widx == IDX_W'(g)) begin
          base_q[g] <= wbase;
          len_q[g]  <= wlen;
        end
      end
    end
  endgenerate

  assign rbase = base_q[ridx];
  assign rlen  = len_q[ridx];
endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  p_reload_only_expired_r2: assert property (@(posedge clk) disable iff (rst)
    load |-> expired);
  p_count_down_r2: assert property (@(posedge clk) disable iff (rst)
    (!load && !expired) |=> ($past(cnt) == cnt + 1'b1));
endmodule

// File: rtl/ccd_frag_seq.sv
module ccd_frag_seq
  import ccd_frag_pkg::*;
#(
  parameter int PAT_W  = 16,
  parameter int HOLD_W = 12,
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 4,
  parameter int REP_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wd_we,
  input  logic [ADDR_W-1:0] wd_addr,
  input  logic [PAT_W-1:0]  wd_pat,
  input  logic [HOLD_W-1:0] wd_hold,
  input  logic              ft_we,
  input  logic [IDX_W-1:0]  ft_idx,
  input  logic [ADDR_W-1:0] ft_base,
  input  logic [ADDR_W:0]   ft_len,
  input  logic              req,
  input  logic [IDX_W-1:0]  req_frag,
  input  logic [REP_W-1:0]  req_reps,
  output logic [PAT_W-1:0]  line_pat,
  output logic              busy,
  output logic              done
);
  localparam int WORD_W = PAT_W + HOLD_W;
  localparam int LEN_W  = ADDR_W + 1;

  sq_state_e         state;
  logic [ADDR_W-1:0] base_r;
  logic [LEN_W-1:0]  len_r;
  logic [LEN_W-1:0]  ptr;
  logic [REP_W-1:0]  reps_left;
  logic [PAT_W-1:0]  pat_r;
  logic              done_r;

  logic [ADDR_W-1:0] tb_base;
  logic [LEN_W-1:0]  tb_len;
  logic [ADDR_W-1:0] raddr;
  logic [WORD_W-1:0] rword;
  logic              t_exp;
  logic              last_word;
  logic              do_load;
  logic              do_finish;
  logic              accept;
  logic              empty_job;
  logic [LEN_W-1:0]  ptr_nxt;

  frag_table #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_table (
    .clk(clk), .rst(rst), .we(ft_we), .widx(ft_idx), .wbase(ft_base),
    .wlen(ft_len), .ridx(req_frag), .rbase(tb_base), .rlen(tb_len)
  );

  frag_word_ram #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) u_ram (
    .clk(clk), .we(wd_we), .waddr(wd_addr), .wdata({wd_pat, wd_hold}),
    .raddr(raddr), .rdata(rword)
  );

  hold_timer #(.CNT_W(HOLD_W)) u_timer (
    .clk(clk), .rst(rst), .load(do_load), .load_val(rword[HOLD_W-1:0]),
    .expired(t_exp)
  );

  assign last_word = (ptr == len_r - 1'b1);
  assign do_load   = (state == SQ_RUN) && t_exp && (reps_left != '0);
  assign do_finish = (state == SQ_RUN) && t_exp && (reps_left == '0);
  assign accept    = (state == SQ_IDLE) && req;
  assign empty_job = (tb_len == '0) || (req_reps == '0);
  assign ptr_nxt   = last_word ? '0 : ptr + 1'b1;

  // The RAM always holds the word at base+ptr ready for the next load.
  always_comb begin
    if (state == SQ_IDLE)  raddr = tb_base;
    else if (do_load)      raddr = base_r + ptr_nxt[ADDR_W-1:0];
    else                   raddr = base_r + ptr[ADDR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      base_r    <= '0;
      len_r     <= '0;
      ptr       <= '0;
      reps_left <= '0;
      pat_r     <= '0;
      done_r    <= 1'b0;
    end else begin
      done_r <= 1'b0;
      if (accept) begin
        if (empty_job) begin
          done_r <= 1'b1;
        end else begin
          state     <= SQ_RUN;
          base_r    <= tb_base;
          len_r     <= tb_len;
          ptr       <= '0;
          reps_left <= req_reps;
        end
      end else if (do_load) begin
        pat_r <= rword[WORD_W-1:HOLD_W];
        ptr   <= ptr_nxt;
        if (last_word) reps_left <= reps_left - 1'b1;
      end else if (do_finish) begin
        state  <= SQ_IDLE;
        done_r <= 1'b1;
      end
    end
  end

  assign line_pat = pat_r;
  assign busy     = (state == SQ_RUN);
  assign done     = done_r;

  p_done_not_busy_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  p_busy_fall_done_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  p_hold_stable_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && !t_exp) |=> $stable(line_pat));
  p_ignore_req_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && req && !t_exp) |=> (busy && $stable(base_r) && $stable(len_r)));
  p_idle_pat_r9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(accept && !empty_job)) |=> $stable(line_pat));
endmodule

// File: tb/test_ccd_frag_seq.sv
module test_ccd_frag_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wd_we = 1'b0;
  logic [7:0]  wd_addr = '0;
  logic [15:0] wd_pat = '0;
  logic [11:0] wd_hold = '0;
  logic        ft_we = 1'b0;
  logic [3:0]  ft_idx = '0;
  logic [7:0]  ft_base = '0;
  logic [8:0]  ft_len = '0;
  logic        req = 1'b0;
  logic [3:0]  req_frag = '0;
  logic [15:0] req_reps = '0;
  logic [15:0] line_pat;
  logic        busy;
  logic        done;

  always #2 clk = ~clk;

  ccd_frag_seq i_ccd_frag_seq (
    .clk(clk), .rst(rst), .wd_we(wd_we), .wd_addr(wd_addr), .wd_pat(wd_pat),
    .wd_hold(wd_hold), .ft_we(ft_we), .ft_idx(ft_idx), .ft_base(ft_base),
    .ft_len(ft_len), .req(req), .req_frag(req_frag), .req_reps(req_reps),
    .line_pat(line_pat), .busy(busy), .done(done)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  int    cyc = 0;
  string cur_req = "R1";

  // reference model state
  int sh_pat  [256];
  int sh_hold [256];
  int sh_base [16];
  int sh_len  [16];
  int q[$];
  int m_pat = 0;
  int m_busy = 0;
  int m_done = 0;

  initial begin
    for (int i = 0; i < 256; i++) begin sh_pat[i] = 0; sh_hold[i] = 0; end
    for (int i = 0; i < 16; i++) begin sh_base[i] = 0; sh_len[i] = 0; end
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst) begin
      q.delete(); m_pat = 0; m_busy = 0; m_done = 0;
      for (int i = 0; i < 16; i++) begin sh_base[i] = 0; sh_len[i] = 0; end
    end else begin
      automatic int acc = (req && m_busy == 0);
      m_done = 0;
      if (q.size() > 0) begin
        automatic int v = q.pop_front();
        if (v < 0) begin m_done = 1; m_busy = 0; end
        else m_pat = v;
      end
      if (acc) begin
        if (req_reps == 0 || sh_len[req_frag] == 0) m_done = 1;
        else begin
          for (int r = 0; r < int'(req_reps); r++)
            for (int k = 0; k < sh_len[req_frag]; k++) begin
              automatic int a = (sh_base[req_frag] + k) % 256;
              for (int h = 0; h <= sh_hold[a]; h++) q.push_back(sh_pat[a]);
            end
          q.push_back(-1);
          m_busy = 1;
        end
      end
      if (wd_we) begin sh_pat[wd_addr] = wd_pat; sh_hold[wd_addr] = wd_hold; end
      if (ft_we) begin sh_base[ft_idx] = ft_base; sh_len[ft_idx] = ft_len; end
    end
  end

  task automatic check(string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", cur_req, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check("line_pat", int'(line_pat), m_pat);
      check("busy", int'(busy), m_busy);
      check("done", int'(done), m_done);
    end
  end

  task automatic put_word(int a, int p, int h);
    @(negedge clk);
    wd_we = 1'b1; wd_addr = 8'(a); wd_pat = 16'(p); wd_hold = 12'(h);
    @(negedge clk);
    wd_we = 1'b0;
  endtask

  task automatic put_frag(int i, int b, int l);
    @(negedge clk);
    ft_we = 1'b1; ft_idx = 4'(i); ft_base = 8'(b); ft_len = 9'(l);
    @(negedge clk);
    ft_we = 1'b0;
  endtask

  task automatic go(int f, int r);
    @(negedge clk);
    req = 1'b1; req_frag = 4'(f); req_reps = 16'(r);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy || m_busy != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    cur_req = "R1";
    check("reset busy", int'(busy), 0);
    check("reset done", int'(done), 0);
    check("reset line_pat", int'(line_pat), 0);
    rst = 1'b0;

    for (int a = 0; a < 16; a++) put_word(a, 16'hA500 + a * 3, (a * 7) % 5);
    put_word(20, 16'h1234, 0);
    for (int a = 250; a < 256; a++) put_word(a, 16'h5A00 + a, a % 3);
    for (int a = 0; a < 4; a++) put_word(a + 40, 16'hC0DE ^ a, 2);
    put_frag(0, 0, 3);
    put_frag(1, 20, 1);
    put_frag(2, 252, 6);
    put_frag(3, 7, 0);
    put_frag(5, 40, 4);

    cur_req = "R2"; go(0, 1); wait_idle();
    cur_req = "R3"; go(2, 1); wait_idle();
    cur_req = "R4"; go(0, 3); wait_idle();
    cur_req = "R4"; go(1, 5); wait_idle();
    cur_req = "R6"; go(5, 2);
    repeat (3) @(negedge clk);
    go(1, 1); go(0, 4); wait_idle();
    cur_req = "R7"; go(0, 0); repeat (2) @(negedge clk);
    go(3, 2); repeat (2) @(negedge clk);
    cur_req = "R8"; put_frag(3, 10, 2); go(3, 2); wait_idle();
    cur_req = "R5";
    go(1, 1);
    while (!done) @(negedge clk);
    go(5, 1); wait_idle();
    cur_req = "R9"; repeat (5) @(negedge clk);
    check("final line_pat", int'(line_pat), 16'hC0DE ^ 3);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog %s: actual hung expected finished", cur_req);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule